// File: doc/BRIEF.md
# Shadowed-Readout Real-Time Clock

This block is a real-time clock that keeps a seconds count and a milliseconds count. A 32 kHz timebase advances them, arriving as a one-cycle tick enable in the system clock domain. Software reaches it through a flat 32-bit register port with an address, a write enable, a read strobe, write data and combinational read data. The counters live on the timebase side. After every eighth tick a short transfer window publishes them to the bus side. A busy flag is raised for the length of that window, and writes to the time and alarm registers that arrive during it are discarded.

To read the time coherently, software reads milliseconds with the read strobe. That read captures the published seconds into a shadow register, which software reads next. Two seconds alarms and one milliseconds alarm set sticky status bits. Software clears these bits by writing ones to the status register. An active-high interrupt line is raised while any status bit is set together with its mask bit. The milliseconds count comes from a fractional accumulator, so exactly `MS_PER_S` millisecond steps fall in every `TICK_HZ` ticks.

Top module: `rtc_shadow_top`

## Requirements
- R1: After reset, every register reads zero, busy (offset 0x04, bit 0) reads 0 and irq is low.
- R2: After k ticks since the last seconds load, the milliseconds register (offset 0x10) reads floor(k*MS_PER_S/TICK_HZ), once a transfer has occurred.
- R3: The milliseconds count wraps from MS_PER_S-1 to 0, and seconds (offset 0x08) increments on that same tick.
- R4: On the eighth tick of every group of eight, busy bit 0 becomes 1 for XFER_CYCLES clocks. When busy ends, the bus-side seconds and milliseconds hold the counter values.
- R5: A read of offset 0x10 with the read strobe copies the bus-side seconds into the shadow register (offset 0x0C). The shadow keeps that value until the next such read.
- R6: A write to seconds while busy is 0 loads the counter and the bus-side copy immediately, and clears the milliseconds count and its fraction.
- R7: Writes to seconds, seconds alarm 0 (0x14), seconds alarm 1 (0x18) and the milliseconds alarm (0x1C) are dropped while busy is 1.
- R8: Status bit 0 (alarm 0) or bit 1 (alarm 1) of offset 0x2C sets on the tick where seconds becomes equal to that alarm value.
- R9: When seconds alarm 0 holds zero, status bit 0 is never set.
- R10: Status bit 2 sets on the tick where milliseconds becomes equal to the milliseconds alarm. Bits 3 and 4 are never set by the hardware.
- R11: Status bits stay set whatever the mask says. Writing a 1 clears a bit, so 0xFFFFFFFF clears all of them, and writing a 0 leaves a bit unchanged.
- R12: Mask bits 4:0 (offset 0x28) follow the status layout, and irq is high exactly while some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per 32 kHz timebase tick |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read strobe (needed for the shadow capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Active-high interrupt |

## Verification
The millisecond counter is driven in steps of tick counts that sit just below the second boundary, exactly on it and just past it. These separate off-by-one errors in the fractional accumulator from errors in the carry into seconds. The seconds counter is preloaded to all ones with alarm 0 at zero, so the wrap to zero shows whether the disable rule is honoured. Writes are issued inside a busy window and outside it, which tells a gated write apart from an ungated one. Several mask and clear patterns are applied to set status bits, to show that the status register, the mask and the interrupt line act independently.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam int IRQ_N  = 5;

  localparam logic [BUS_AW-1:0] OFS_BUSY   = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_SEC    = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_SHADOW = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_MSEC   = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_ALM0   = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_ALM1   = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_MALM   = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_MASK   = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_STAT   = 8'h2C;

  // status / mask bit positions
  localparam int EV_SALM0 = 0;
  localparam int EV_SALM1 = 1;
  localparam int EV_MALM  = 2;
  localparam int EV_SCDN  = 3;
  localparam int EV_MCDN  = 4;
endpackage

// File: rtl/rtc_xfer_window.sv
// Counts timebase ticks in groups and opens a busy window after the last
// tick of each group; copy_pulse marks the final busy cycle.
module rtc_xfer_window #(
  parameter int PHASES      = 8,
  parameter int XFER_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic busy,
  output logic copy_pulse
);
  localparam int PH_W  = $clog2(PHASES);
  localparam int CNT_W = $clog2(XFER_CYCLES + 1);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [CNT_W-1:0] win_q, win_d;

  always_comb begin
    phase_d = phase_q;
    win_d   = win_q;
    if (win_q != '0) win_d = win_q - 1'b1;
    if (tick_en) begin
      if (phase_q == PH_W'(PHASES - 1)) begin
        phase_d = '0;
        win_d   = CNT_W'(XFER_CYCLES);
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      win_q   <= '0;
    end else begin
      phase_q <= phase_d;
      win_q   <= win_d;
    end
  end

  assign busy       = (win_q != '0);
  assign copy_pulse = (win_q == CNT_W'(1));
endmodule

// File: rtl/rtc_time_core.sv
// Timebase-side counters: fractional accumulator -> milliseconds -> seconds.
module rtc_time_core #(
  parameter int TICK_HZ  = 32768,
  parameter int MS_PER_S = 1000,
  parameter int SEC_W    = 32,
  parameter int MS_W     = $clog2(MS_PER_S)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_sec,
  output logic [SEC_W-1:0] sec_q,
  output logic [MS_W-1:0]  ms_q,
  output logic [SEC_W-1:0] sec_nxt,
  output logic [MS_W-1:0]  ms_nxt,
  output logic             sec_inc,
  output logic             ms_inc
);
  localparam int ACC_W = $clog2(TICK_HZ);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             ms_wrap;

  always_comb begin
    sum     = {1'b0, acc_q} + (ACC_W+1)'(MS_PER_S);
    ms_inc  = tick_en && !load_en && (sum >= (ACC_W+1)'(TICK_HZ));
    ms_wrap = ms_inc && (ms_q == MS_W'(MS_PER_S - 1));
    sec_inc = ms_wrap;
    acc_d   = acc_q;
    ms_nxt  = ms_q;
    sec_nxt = sec_q;
    if (load_en) begin
      acc_d   = '0;
      ms_nxt  = '0;
      sec_nxt = load_sec;
    end else if (tick_en) begin
      if (ms_inc) begin
        acc_d  = ACC_W'(sum - (ACC_W+1)'(TICK_HZ));
        ms_nxt = ms_wrap ? '0 : ms_q + 1'b1;
        if (ms_wrap) sec_nxt = sec_q + 1'b1;
      end else begin
        acc_d = sum[ACC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      acc_q <= acc_d;
      ms_q  <= ms_nxt;
      sec_q <= sec_nxt;
    end
  end
endmodule

// File: rtl/rtc_reg_bank.sv
// Bus-side registers: published time, shadow, alarms, mask, status, read mux.
module rtc_reg_bank
  import rtc_shadow_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int MS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              busy,
  input  logic              copy_pulse,
  input  logic [SEC_W-1:0]  sec_q,
  input  logic [MS_W-1:0]   ms_q,
  input  logic [SEC_W-1:0]  sec_nxt,
  input  logic [MS_W-1:0]   ms_nxt,
  input  logic              sec_inc,
  input  logic              ms_inc,
  output logic              load_en,
  output logic [SEC_W-1:0]  load_sec,
  output logic [SEC_W-1:0]  alm0_o,
  output logic [IRQ_N-1:0]  stat_o,
  output logic [IRQ_N-1:0]  mask_o,
  output logic              irq
);
  logic [SEC_W-1:0] sec_vis_q, sec_vis_d, shadow_q, shadow_d;
  logic [SEC_W-1:0] alm0_q, alm0_d, alm1_q, alm1_d;
  logic [MS_W-1:0]  ms_vis_q, ms_vis_d, malm_q, malm_d;
  logic [IRQ_N-1:0] mask_q, mask_d, stat_q, stat_d, ev_set, ev_clr;
  logic             wr_open;

  assign wr_open  = bus_we && !busy;
  assign load_en  = wr_open && (bus_addr == OFS_SEC);
  assign load_sec = bus_wdata[SEC_W-1:0];

  always_comb begin
    sec_vis_d = sec_vis_q;
    ms_vis_d  = ms_vis_q;
    if (load_en) begin
      sec_vis_d = load_sec;
      ms_vis_d  = '0;
    end else if (copy_pulse) begin
      sec_vis_d = sec_q;
      ms_vis_d  = ms_q;
    end

    shadow_d = (bus_re && bus_addr == OFS_MSEC) ? sec_vis_q : shadow_q;

    alm0_d = (wr_open && bus_addr == OFS_ALM0) ? bus_wdata[SEC_W-1:0] : alm0_q;
    alm1_d = (wr_open && bus_addr == OFS_ALM1) ? bus_wdata[SEC_W-1:0] : alm1_q;
    malm_d = (wr_open && bus_addr == OFS_MALM) ? bus_wdata[MS_W-1:0]  : malm_q;
    mask_d = (bus_we && bus_addr == OFS_MASK)  ? bus_wdata[IRQ_N-1:0] : mask_q;

    ev_set           = '0;
    ev_set[EV_SALM0] = sec_inc && (sec_nxt == alm0_q) && (alm0_q != '0);
    ev_set[EV_SALM1] = sec_inc && (sec_nxt == alm1_q);
    ev_set[EV_MALM]  = ms_inc && (ms_nxt == malm_q);
    ev_set[EV_SCDN]  = 1'b0;
    ev_set[EV_MCDN]  = 1'b0;
    ev_clr = (bus_we && bus_addr == OFS_STAT) ? bus_wdata[IRQ_N-1:0] : '0;
    stat_d = (stat_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_vis_q <= '0;
      ms_vis_q  <= '0;
      shadow_q  <= '0;
      alm0_q    <= '0;
      alm1_q    <= '0;
      malm_q    <= '0;
      mask_q    <= '0;
      stat_q    <= '0;
    end else begin
      sec_vis_q <= sec_vis_d;
      ms_vis_q  <= ms_vis_d;
      shadow_q  <= shadow_d;
      alm0_q    <= alm0_d;
      alm1_q    <= alm1_d;
      malm_q    <= malm_d;
      mask_q    <= mask_d;
      stat_q    <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_BUSY:   bus_rdata[0]          = busy;
      OFS_SEC:    bus_rdata[SEC_W-1:0]  = sec_vis_q;
      OFS_SHADOW: bus_rdata[SEC_W-1:0]  = shadow_q;
      OFS_MSEC:   bus_rdata[MS_W-1:0]   = ms_vis_q;
      OFS_ALM0:   bus_rdata[SEC_W-1:0]  = alm0_q;
      OFS_ALM1:   bus_rdata[SEC_W-1:0]  = alm1_q;
      OFS_MALM:   bus_rdata[MS_W-1:0]   = malm_q;
      OFS_MASK:   bus_rdata[IRQ_N-1:0]  = mask_q;
      OFS_STAT:   bus_rdata[IRQ_N-1:0]  = stat_q;
      default:    bus_rdata             = '0;
    endcase
  end

  assign irq    = |(stat_q & mask_q);
  assign alm0_o = alm0_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
  import rtc_shadow_pkg::*;
#(
  parameter int TICK_HZ     = 32768,
  parameter int MS_PER_S    = 1000,
  parameter int SEC_W       = 32,
  parameter int PHASES      = 8,
  parameter int XFER_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int MS_W = $clog2(MS_PER_S);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             busy_w, copy_w, load_w, sec_inc_w, ms_inc_w;
  logic [SEC_W-1:0] sec_q_w, sec_nxt_w, load_sec_w, alm0_w;
  logic [MS_W-1:0]  ms_q_w, ms_nxt_w;
  logic [IRQ_N-1:0] stat_w, mask_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rtc_xfer_window #(.PHASES(PHASES), .XFER_CYCLES(XFER_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_int_n), .tick_en(tick_en),
    .busy(busy_w), .copy_pulse(copy_w)
  );

  rtc_time_core #(.TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S), .SEC_W(SEC_W), .MS_W(MS_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .tick_en(tick_en),
    .load_en(load_w), .load_sec(load_sec_w),
    .sec_q(sec_q_w), .ms_q(ms_q_w), .sec_nxt(sec_nxt_w), .ms_nxt(ms_nxt_w),
    .sec_inc(sec_inc_w), .ms_inc(ms_inc_w)
  );

  rtc_reg_bank #(.SEC_W(SEC_W), .MS_W(MS_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .copy_pulse(copy_w),
    .sec_q(sec_q_w), .ms_q(ms_q_w), .sec_nxt(sec_nxt_w), .ms_nxt(ms_nxt_w),
    .sec_inc(sec_inc_w), .ms_inc(ms_inc_w),
    .load_en(load_w), .load_sec(load_sec_w),
    .alm0_o(alm0_w), .stat_o(stat_w), .mask_o(mask_w), .irq(irq)
  );
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
  import rtc_shadow_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int MS_PER_S = 1000,
  parameter int MS_W     = $clog2(MS_PER_S)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              busy,
  input logic [SEC_W-1:0]  sec_q,
  input logic [MS_W-1:0]   ms_q,
  input logic [SEC_W-1:0]  alm0,
  input logic [IRQ_N-1:0]  stat,
  input logic [IRQ_N-1:0]  mask,
  input logic              irq
);
  AST_BUSY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick_en)); // R4

  AST_MS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ms_q} < (MS_W+1)'(MS_PER_S)); // R3

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_SEC && busy && !tick_en) |=> (sec_q == $past(sec_q))); // R7

  AST_ALM0_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (alm0 == '0) |=> !$rose(stat[EV_SALM0])); // R9

  AST_STAT_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[EV_SALM0]) |-> $past(bus_we && bus_addr == OFS_STAT)); // R11

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R12
endmodule

bind rtc_shadow_top rtc_shadow_chk #(.SEC_W(SEC_W), .MS_PER_S(MS_PER_S)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .busy(busy_w), .sec_q(sec_q_w), .ms_q(ms_q_w), .alm0(alm0_w),
  .stat(stat_w), .mask(mask_w), .irq(irq)
);

// File: tb/rtc_shadow_top_tb_top.sv
`timescale 1ns/1ps
module rtc_shadow_top_tb_top;
  localparam int TICK_HZ = 2048;
  localparam int XFER    = 2;
  localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10,
                         A_AL0 = 8'h14, A_AL1 = 8'h18, A_MAL = 8'h1C,
                         A_MSK = 8'h28, A_STS = 8'h2C;
  // {ticks to add, expected ms, expected seconds offset}
  localparam int VEC_N = 7;
  localparam int VEC [VEC_N][3] = '{
    '{8, 3, 0}, '{8, 7, 0}, '{240, 125, 0}, '{768, 500, 0},
    '{1016, 996, 0}, '{8, 0, 1}, '{8, 3, 1}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  rtc_shadow_top #(.TICK_HZ(TICK_HZ), .XFER_CYCLES(XFER)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one tick, then idle long enough for any transfer window to finish
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk) begin bus_addr = a; bus_wdata = d; bus_we = 1'b1; end
    @(negedge clk) bus_we = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, input bit strobe, output logic [31:0] d);
    @(negedge clk) begin bus_addr = a; bus_re = strobe; end
    #1 d = bus_rdata;
    @(negedge clk) bus_re = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rdr(A_BUSY, 0, rd); check("R1 busy", rd, 0);
    rdr(A_SEC, 0, rd);  check("R1 seconds", rd, 0);
    rdr(A_MS, 0, rd);   check("R1 msec", rd, 0);
    rdr(A_SHD, 0, rd);  check("R1 shadow", rd, 0);
    rdr(A_AL0, 0, rd);  check("R1 alarm0", rd, 0);
    rdr(A_STS, 0, rd);  check("R1 status", rd, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R6 accepted load
    wr(A_SEC, 1000);
    rdr(A_SEC, 0, rd); check("R6 seconds load", rd, 1000);
    rdr(A_MS, 0, rd);  check("R6 msec cleared", rd, 0);

    // R2 / R3 vector walk
    for (int v = 0; v < VEC_N; v++) begin
      ticks(VEC[v][0]);
      rdr(A_MS, 0, rd);  check($sformatf("R2 msec vec%0d", v), rd, VEC[v][1]);
      rdr(A_SEC, 0, rd); check($sformatf("R3 seconds vec%0d", v), rd, 1000 + VEC[v][2]);
    end

    // R5 shadow capture
    rdr(A_MS, 1, rd);
    rdr(A_SHD, 0, rd); check("R5 shadow capture", rd, 1001);
    wr(A_SEC, 5000);
    rdr(A_SHD, 0, rd); check("R5 shadow held", rd, 1001);
    rdr(A_MS, 1, rd);
    rdr(A_SHD, 0, rd); check("R5 shadow recapture", rd, 5000);

    // R4 / R7 busy window and dropped writes
    ticks(7);
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) begin
      tick_en = 1'b0; bus_addr = A_BUSY;
      #1 check("R4 busy raised", bus_rdata, 1);
      bus_addr = A_SEC; bus_wdata = 7; bus_we = 1'b1;
    end
    @(negedge clk) begin bus_addr = A_AL0; bus_wdata = 9; end
    @(negedge clk) bus_we = 1'b0;
    rdr(A_BUSY, 0, rd); check("R4 busy cleared", rd, 0);
    rdr(A_SEC, 0, rd);  check("R7 seconds write dropped", rd, 5000);
    rdr(A_MS, 0, rd);   check("R4 msec published", rd, 3);
    rdr(A_AL0, 0, rd);  check("R7 alarm write dropped", rd, 0);

    // R10 millisecond alarm, R8 seconds alarms, R11, R12
    wr(A_SEC, 100); wr(A_AL0, 101); wr(A_AL1, 102); wr(A_MAL, 3);
    ticks(8);
    rdr(A_STS, 0, rd); check("R10 msec alarm", rd, 32'h4);
    wr(A_STS, 32'h4);
    rdr(A_STS, 0, rd); check("R11 w1c bit2", rd, 0);
    ticks(2040);
    rdr(A_SEC, 0, rd); check("R3 seconds 101", rd, 101);
    rdr(A_STS, 0, rd); check("R8 alarm0 only", rd, 32'h1);
    check("R12 irq masked", {31'b0, irq}, 0);
    wr(A_MSK, 32'h1);
    check("R12 irq enabled", {31'b0, irq}, 1);
    wr(A_MSK, 32'h2);
    check("R12 irq other mask", {31'b0, irq}, 0);
    wr(A_STS, 32'h2);
    rdr(A_STS, 0, rd); check("R11 zero bit kept", rd, 32'h1);
    wr(A_STS, 32'hFFFF_FFFF);
    rdr(A_STS, 0, rd); check("R11 clear all", rd, 0);
    ticks(2048);
    rdr(A_STS, 0, rd); check("R8 alarm1", rd, 32'h6);
    check("R12 irq alarm1", {31'b0, irq}, 1);
    wr(A_STS, 32'hFFFF_FFFF); wr(A_MSK, 0);

    // R9 alarm0 zero never fires across seconds wrap
    wr(A_AL0, 0); wr(A_SEC, 32'hFFFF_FFFF);
    ticks(2048);
    rdr(A_SEC, 0, rd); check("R3 seconds wrap", rd, 0);
    rdr(A_STS, 0, rd); check("R9 alarm0 disabled", rd & 32'h1, 0);
    check("R10 countdown bits clear", rd & 32'h18, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule